// File: doc/BRIEF.md
# T1 Framing Bit Error Counter

This block compares every received T1 framing bit with the bit that the active framing pattern expects at the current frame of the superframe. It counts each mismatch in an 8-bit register. The register stops at its maximum value and does not wrap. It can be loaded from a simple write port. Once the count is full, each further error raises a one-cycle interrupt pulse, provided the interrupt enable input is high.

A frame position tracker follows the superframe. It steps on a frame strobe and is forced back to frame 1 by a superframe-start input. Two superframe modes are supported:

- **Standard-superframe mode (12 frames):** odd frames carry terminal framing bits, which are always checked. Even frames carry signalling framing bits, which are checked only when a control input allows it.
- **Extended-superframe mode (24 frames):** only every fourth frame carries a framing pattern bit, and only those frames are checked.

While the loss-of-sync input is high, nothing is counted and no interrupt is raised.

The counter's control is a two-state machine:

| State | Meaning |
|---|---|
| `TALLY_OPEN` | The count is below its maximum. |
| `TALLY_FULL` | The count is saturated at its maximum. |

| Transition | Cause |
|---|---|
| **Fill** (`TALLY_OPEN` to `TALLY_FULL`) | A counted error moves the count from 254 to 255, or a preset loads 255. |
| **Reload** (`TALLY_FULL` to `TALLY_OPEN`) | A preset loads any value below 255. |
| **Stay** (either state to itself) | Every other cycle. |

Top module: `frm_bit_err_cnt`

## Requirements
- R1: After reset, `count` is 0, `irq` is low and the frame position is frame 1.
- R2: The frame position advances by one on each `frame_stb`. It returns to 1 after frame 12 in standard mode, or after frame 24 in extended mode. `sf_start` forces frame 1 and takes priority over `frame_stb` in the same cycle.
- R3: In standard mode (`esf_mode`=0), odd frames 1,3,5,7,9,11 expect framing bits 1,0,1,0,1,0 in that order. A mismatch is always counted.
- R4: In standard mode, even frames 2,4,6,8,10,12 expect 0,0,1,1,1,0 in that order. A mismatch is counted only when `fs_check_en`=1 and has no effect when it is 0.
- R5: In extended mode (`esf_mode`=1), frames 4,8,12,16,20,24 expect 0,0,1,0,1,1 in that order. A bit in any other frame is never counted.
- R6: Each checked bit presented with `fbit_vld`=1 that differs from the expected bit raises `count` by exactly one, visible after the next clock edge. A bit presented with `fbit_vld`=0 has no effect.
- R7: The count saturates at 255 and never wraps to 0.
- R8: When `count` is already 255, each further counted error produces a one-cycle `irq` pulse after the next edge, but only if `irq_en`=1. With `irq_en`=0 no pulse appears.
- R9: While `los`=1, errors change neither `count` nor `irq`.
- R10: `preset_we`=1 loads `preset_data` into `count` at the next edge. This takes priority over an error in the same cycle, and that error raises no `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| esf_mode | input | 1 | 1 = extended 24-frame mode, 0 = standard 12-frame mode |
| fs_check_en | input | 1 | Enables checking of even-frame signalling bits in standard mode |
| los | input | 1 | Loss of sync; suspends counting and interrupts |
| irq_en | input | 1 | Interrupt enable for errors after saturation |
| frame_stb | input | 1 | Advance the frame position after this cycle |
| sf_start | input | 1 | Force the frame position to 1 |
| fbit_vld | input | 1 | `fbit` holds the framing bit of the current frame |
| fbit | input | 1 | Received framing bit |
| preset_we | input | 1 | Load `preset_data` into the count |
| preset_data | input | 8 | Value to load |
| count | output | 8 | Current error count |
| irq | output | 1 | One-cycle pulse for an error while saturated |

## Verification
The two functions that can fall in the same cycle are:

- **A preset write and a counted framing error.** The bench presents a wrong frame-1 bit in exactly the cycle that carries a preset, with the count already saturated and interrupts enabled. It then expects the preset value and no pulse.
- **Superframe realignment and the frame strobe.** The bench asserts both together in the middle of a superframe. It then expects the next error to be judged against the frame-1 bit.

A sweep over both modes, both settings of the signalling check, two passes of each superframe and a mix of valid, invalid, correct and wrong bits compares the count after every frame with an arithmetic model.

// File: rtl/fbe_pkg.sv
package fbe_pkg;

    // Number of bits in each framing sequence.
    localparam int PAT_LEN = 6;

    // Framing sequences. The MSB is the bit expected in the first frame
    // that carries the sequence.
    localparam logic [PAT_LEN-1:0] TERM_SEQ = 6'b101010;
    localparam logic [PAT_LEN-1:0] SIG_SEQ  = 6'b001110;
    localparam logic [PAT_LEN-1:0] EXT_SEQ  = 6'b001011;

    // A standard superframe holds one terminal bit and one signalling bit
    // per sequence position.
    localparam int STD_FRAMES = 2 * PAT_LEN;

    typedef enum logic {
        TALLY_OPEN,
        TALLY_FULL
    } tally_state_e;

    typedef struct packed {
        logic check;
        logic expect_bit;
    } fbit_ref_t;

endpackage

// File: rtl/fbe_pos_track.sv
module fbe_pos_track
    import fbe_pkg::*;
#(
    parameter int EXT_FRAMES = 24,
    parameter int POS_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             esf_mode,
    input  logic             frame_stb,
    input  logic             sf_start,
    output logic [POS_W-1:0] pos
);

    logic [POS_W-1:0] last_frame;

    assign last_frame = esf_mode ? POS_W'(EXT_FRAMES) : POS_W'(STD_FRAMES);

    // sf_start wins over frame_stb; after the last frame the position wraps to 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= POS_W'(1);
        end else if (sf_start) begin
            pos <= POS_W'(1);
        end else if (frame_stb) begin
            if (pos >= last_frame) begin
                pos <= POS_W'(1);
            end else begin
                pos <= pos + POS_W'(1);
            end
        end
    end

endmodule

// File: rtl/fbe_pattern_ref.sv
module fbe_pattern_ref
    import fbe_pkg::*;
#(
    parameter int EXT_FRAMES = 24,
    parameter int POS_W      = 5
) (
    input  logic             esf_mode,
    input  logic             fs_check_en,
    input  logic [POS_W-1:0] pos,
    output fbit_ref_t        ref_o
);

    // Frames between two extended-mode framing bits.
    localparam int EXT_STEP = EXT_FRAMES / PAT_LEN;

    // Returns bit number idx of a sequence, counted from the first bit sent.
    // An index past the end of the sequence shifts everything out and gives 0.
    function automatic logic seq_bit(input logic [PAT_LEN-1:0] seq, input int idx);
        logic [PAT_LEN-1:0] shifted;
        shifted = seq << idx;
        return shifted[PAT_LEN-1];
    endfunction

    int frame_n;

    always_comb begin
        frame_n = int'(pos);
        ref_o   = '0;
        if (frame_n > 0) begin
            if (esf_mode) begin
                if ((frame_n % EXT_STEP) == 0) begin
                    ref_o.check      = 1'b1;
                    ref_o.expect_bit = seq_bit(EXT_SEQ, (frame_n / EXT_STEP) - 1);
                end
            end else if ((frame_n % 2) == 1) begin
                ref_o.check      = 1'b1;
                ref_o.expect_bit = seq_bit(TERM_SEQ, (frame_n - 1) / 2);
            end else begin
                ref_o.check      = fs_check_en;
                ref_o.expect_bit = seq_bit(SIG_SEQ, (frame_n / 2) - 1);
            end
        end
    end

endmodule

// File: rtl/fbe_tally.sv
module fbe_tally
    import fbe_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             irq_en,
    input  logic             preset_we,
    input  logic [CNT_W-1:0] preset_val,
    output logic [CNT_W-1:0] count,
    output logic             irq
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_PRE = CNT_MAX - CNT_W'(1);

    tally_state_e     st_q;
    tally_state_e     st_d;
    logic [CNT_W-1:0] cnt_d;
    logic             irq_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= TALLY_OPEN;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic and next values of the outputs.
    always_comb begin
        st_d  = st_q;
        cnt_d = count;
        irq_d = 1'b0;
        unique case (st_q)
            TALLY_OPEN: begin
                if (preset_we) begin
                    cnt_d = preset_val;
                    st_d  = (preset_val == CNT_MAX) ? TALLY_FULL : TALLY_OPEN;
                end else if (hit) begin
                    cnt_d = count + CNT_W'(1);
                    if (count == CNT_PRE) begin
                        st_d = TALLY_FULL;
                    end
                end
            end
            TALLY_FULL: begin
                if (preset_we) begin
                    cnt_d = preset_val;
                    st_d  = (preset_val == CNT_MAX) ? TALLY_FULL : TALLY_OPEN;
                end else if (hit) begin
                    irq_d = irq_en;
                end
            end
            default: begin
                st_d = TALLY_OPEN;
            end
        endcase
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            irq   <= 1'b0;
        end else begin
            count <= cnt_d;
            irq   <= irq_d;
        end
    end

endmodule

// File: rtl/frm_bit_err_cnt.sv
module frm_bit_err_cnt
    import fbe_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int EXT_FRAMES = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             esf_mode,
    input  logic             fs_check_en,
    input  logic             los,
    input  logic             irq_en,
    input  logic             frame_stb,
    input  logic             sf_start,
    input  logic             fbit_vld,
    input  logic             fbit,
    input  logic             preset_we,
    input  logic [CNT_W-1:0] preset_data,
    output logic [CNT_W-1:0] count,
    output logic             irq
);

    localparam int POS_W = $clog2(EXT_FRAMES + 1);

    logic [POS_W-1:0] pos;
    fbit_ref_t        ref_w;
    logic             hit;

    fbe_pos_track #(
        .EXT_FRAMES(EXT_FRAMES),
        .POS_W     (POS_W)
    ) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .esf_mode (esf_mode),
        .frame_stb(frame_stb),
        .sf_start (sf_start),
        .pos      (pos)
    );

    fbe_pattern_ref #(
        .EXT_FRAMES(EXT_FRAMES),
        .POS_W     (POS_W)
    ) u_ref (
        .esf_mode   (esf_mode),
        .fs_check_en(fs_check_en),
        .pos        (pos),
        .ref_o      (ref_w)
    );

    // A counted error: a valid, checked bit that differs from the expected one, while in sync.
    assign hit = fbit_vld & ref_w.check & (fbit ^ ref_w.expect_bit) & ~los;

    fbe_tally #(
        .CNT_W(CNT_W)
    ) u_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .irq_en    (irq_en),
        .preset_we (preset_we),
        .preset_val(preset_data),
        .count     (count),
        .irq       (irq)
    );

endmodule

// File: rtl/fbe_checker.sv
module fbe_checker #(
    parameter int CNT_W      = 8,
    parameter int POS_W      = 5,
    parameter int EXT_FRAMES = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fbit_vld,
    input logic             los,
    input logic             irq_en,
    input logic             preset_we,
    input logic [CNT_W-1:0] preset_data,
    input logic [CNT_W-1:0] count,
    input logic             irq,
    input logic [POS_W-1:0] pos
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R10
    preset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preset_we |=> (count == $past(preset_data)));

    // R7
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX && !preset_we) |=> (count == CNT_MAX));

    // R6
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !preset_we |=> (count == $past(count) || count == $past(count) + CNT_W'(1)));

    // R6
    invalid_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fbit_vld && !preset_we) |=> ($stable(count) && !irq));

    // R9
    los_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (los && !preset_we) |=> ($stable(count) && !irq));

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !irq);

    // R8
    irq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count == CNT_MAX && $past(count) == CNT_MAX));

    // R10
    irq_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preset_we |=> !irq);

    // R2
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos >= POS_W'(1) && pos <= POS_W'(EXT_FRAMES)));

endmodule

bind frm_bit_err_cnt fbe_checker #(
    .CNT_W     (CNT_W),
    .POS_W     (POS_W),
    .EXT_FRAMES(EXT_FRAMES)
) u_fbe_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .fbit_vld   (fbit_vld),
    .los        (los),
    .irq_en     (irq_en),
    .preset_we  (preset_we),
    .preset_data(preset_data),
    .count      (count),
    .irq        (irq),
    .pos        (pos)
);

// File: tb/tb_frm_bit_err_cnt.sv
module tb_frm_bit_err_cnt;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       esf_mode = 1'b0;
    logic       fs_check_en = 1'b0;
    logic       los = 1'b0;
    logic       irq_en = 1'b0;
    logic       frame_stb = 1'b0;
    logic       sf_start = 1'b0;
    logic       fbit_vld = 1'b0;
    logic       fbit = 1'b0;
    logic       preset_we = 1'b0;
    logic [7:0] preset_data = 8'd0;
    logic [7:0] count;
    logic       irq;

    int checks = 0;
    int errors = 0;

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    frm_bit_err_cnt dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .esf_mode   (esf_mode),
        .fs_check_en(fs_check_en),
        .los        (los),
        .irq_en     (irq_en),
        .frame_stb  (frame_stb),
        .sf_start   (sf_start),
        .fbit_vld   (fbit_vld),
        .fbit       (fbit),
        .preset_we  (preset_we),
        .preset_data(preset_data),
        .count      (count),
        .irq        (irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Expected framing bit, worked out from the requirement text.
    task automatic ref_bit(input int f, input bit esf, input bit fsen,
                           output bit chk, output bit eb);
        int k;
        chk = 1'b0;
        eb  = 1'b0;
        if (esf) begin
            if (f % 4 == 0) begin
                k   = f / 4 - 1;
                chk = 1'b1;
                eb  = (k == 2 || k == 4 || k == 5);
            end
        end else if (f % 2 == 1) begin
            k   = (f - 1) / 2;
            chk = 1'b1;
            eb  = (k % 2 == 0);
        end else begin
            k   = f / 2 - 1;
            chk = fsen;
            eb  = (k >= 2 && k <= 4);
        end
    endtask

    task automatic realign();
        sf_start = 1'b1;
        tick();
        sf_start = 1'b0;
    endtask

    task automatic do_preset(input int v);
        preset_we   = 1'b1;
        preset_data = 8'(v);
        tick();
        preset_we   = 1'b0;
    endtask

    // A wrong bit in frame 1 of standard mode (frame 1 expects 1).
    task automatic err_frame1();
        realign();
        fbit_vld = 1'b1;
        fbit     = 1'b0;
        tick();
        fbit_vld = 1'b0;
    endtask

    // The watchdog counts as a failed check and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        int mcnt;
        bit chk;
        bit eb;
        bit flip;
        bit vld;
        int nfr;
        string req;

        repeat (3) tick();
        rst_n = 1'b1;
        check("R1 count after reset", int'(count), 0);
        check("R1 irq after reset", int'(irq), 0);

        // R1: the position starts at frame 1, which expects 1 in standard mode.
        fbit_vld = 1'b1;
        fbit     = 1'b0;
        tick();
        fbit_vld = 1'b0;
        check("R1 first frame is frame 1", int'(count), 1);

        // R2: sf_start together with frame_stb in mid-superframe.
        repeat (3) begin
            frame_stb = 1'b1;
            tick();
        end
        sf_start = 1'b1;
        tick();
        sf_start  = 1'b0;
        frame_stb = 1'b0;
        fbit_vld  = 1'b1;
        fbit      = 1'b0;
        tick();
        fbit_vld  = 1'b0;
        check("R2 sf_start wins over frame_stb", int'(count), 2);

        // Sweep: m=0 standard with signalling check off, m=1 with it on,
        // m=2 extended mode. Two passes each also cover the wrap of R2.
        for (int m = 0; m < 3; m++) begin
            esf_mode    = (m == 2);
            fs_check_en = (m == 1);
            do_preset(0);
            realign();
            mcnt = 0;
            nfr  = (m == 2) ? 24 : 12;
            for (int pass = 0; pass < 2; pass++) begin
                for (int f = 1; f <= nfr; f++) begin
                    ref_bit(f, esf_mode, fs_check_en, chk, eb);
                    flip      = ((f + 3 * pass + m) % 3 == 0);
                    vld       = ((f + pass) % 7 != 0);
                    fbit_vld  = vld;
                    fbit      = eb ^ flip;
                    frame_stb = 1'b1;
                    tick();
                    fbit_vld  = 1'b0;
                    frame_stb = 1'b0;
                    if (chk && flip && vld) mcnt++;
                    if (!vld)           req = "R6 invalid bit";
                    else if (m == 2)    req = (pass == 1) ? "R5 R2 extended second pass" : "R5 extended";
                    else if (f % 2 == 1) req = (pass == 1) ? "R3 R2 terminal second pass" : "R3 terminal";
                    else                req = "R4 signalling";
                    check(req, int'(count), mcnt);
                    check("R8 no irq below saturation", int'(irq), 0);
                end
            end
        end

        // Saturation and interrupts, standard mode.
        esf_mode    = 1'b0;
        fs_check_en = 1'b0;
        irq_en      = 1'b0;
        do_preset(254);
        check("R10 preset load", int'(count), 254);
        err_frame1();
        check("R7 reach 255", int'(count), 255);
        check("R8 no irq when reaching 255", int'(irq), 0);
        err_frame1();
        check("R7 no wrap", int'(count), 255);
        check("R8 masked irq", int'(irq), 0);
        irq_en = 1'b1;
        err_frame1();
        check("R8 irq pulse", int'(irq), 1);
        check("R7 held at 255", int'(count), 255);
        tick();
        check("R8 irq is one cycle", int'(irq), 0);
        err_frame1();
        check("R8 second irq pulse", int'(irq), 1);
        tick();

        // R9: loss of sync freezes everything.
        los = 1'b1;
        err_frame1();
        check("R9 no irq during los", int'(irq), 0);
        check("R9 count during los", int'(count), 255);
        los = 1'b0;

        // R10: preset and error in the same cycle, count saturated.
        realign();
        preset_we   = 1'b1;
        preset_data = 8'd10;
        fbit_vld    = 1'b1;
        fbit        = 1'b0;
        tick();
        preset_we   = 1'b0;
        fbit_vld    = 1'b0;
        check("R10 preset wins over error", int'(count), 10);
        check("R10 no irq with preset", int'(irq), 0);
        los = 1'b1;
        err_frame1();
        check("R9 count frozen below max", int'(count), 10);
        los = 1'b0;
        err_frame1();
        check("R6 count after preset", int'(count), 11);

        // R10 then R8: a preset to 255 saturates directly.
        do_preset(255);
        err_frame1();
        check("R10 preset 255 then error irq", int'(irq), 1);
        check("R7 count stays 255", int'(count), 255);
        tick();

        summary();
        $finish;
    end

endmodule